// File: doc/BRIEF.md
# System Management Interrupt Aggregator

This block gathers interrupt events from on-chip peripheral functions and from general-purpose and fan-tachometer inputs, and merges them into one group management interrupt. Each source has a status bit and an enable bit. The group interrupt is asserted while any enabled status bit is set.

There are two kinds of status. Peripheral statuses follow live levels that their source removes. The one exception is the infrared status, which is held until software reads its register. General-purpose statuses are set by a selected edge, and software clears them by writing 1.

The group interrupt can be steered to three places, each under its own routing bit:
- a dedicated pad with programmable polarity and drive type,
- a request line for the serial-IRQ channel,
- a request line into the power-management-event logic.

A simple register port with separate read and write strobes gives access to all state.

Top module: `smi_aggregator`

## Requirements
- R1: The group interrupt is the OR, over all sources, of each status bit ANDed with its enable bit. The enables are: address 2 for the peripheral levels, address 3 bit 0 for infrared, and address 5 for general-purpose statuses.
- R2: Address 0 reads the live peripheral levels directly. The bit order is parallel 0, serial-A 1, serial-B 2, floppy 3, mouse 4, keyboard 5, P12 6, wake 7. A write to address 0 has no effect.
- R3: The infrared status is set in every cycle where the infrared level is high.
  - A read strobe at address 1 returns the status in bit 0 in that same cycle.
  - The status is cleared at the clock edge that ends the read cycle, unless the level is still high.
- R4: A general-purpose input passes through two synchronizing flops. Its status bit (address 4) is set at the third rising clock edge after the input change is sampled.
  - With polarity bit 0 (address 6), a low-to-high change sets the status.
- R5: With polarity bit 1, only a high-to-low change sets the status.
- R6: With the either-edge bit set (address 7), both transitions set the status, whatever the polarity.
- R7: Writing 1 to a bit of address 4 clears that status bit. Writing 0 leaves it unchanged. If an edge event lands in the same cycle as the clear, the bit stays set.
- R8: Address 3 controls routing:
  - bit 7 routes the group interrupt to the pad;
  - bit 6 drives the serial-IRQ request output;
  - bit 5 drives the power-management request output.
  - Address 3 reads back only bits 7, 6, 5 and 0.
- R9: Address 8 controls the pad. Bit 0 = 1 makes the pad active high. Bit 7 = 1 selects push-pull, in which the output enable is always on and the data reflects the asserted state. In open-drain mode, the output enable is on only while the pad is asserted, and the data is fixed at the active level.
- R10: After reset, every register and status reads 0 and unused addresses read 0. The pad is then active-low, open-drain and released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_evt_i | input | 8 | Live peripheral interrupt levels |
| ir_evt_i | input | 1 | Infrared interrupt level |
| gpio_i | input | NUM_GPIO | General-purpose and tachometer event inputs |
| reg_addr_i | input | 4 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe (side effect on address 1 only) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data (combinational from address) |
| smi_pad_o | output | 1 | Pad data |
| smi_pad_oe_o | output | 1 | Pad output enable |
| serirq_smi_o | output | 1 | Serial-IRQ channel request |
| pme_smi_o | output | 1 | Power-management-event request |

## Verification
The assertions assume the following about the block's inputs:
- Peripheral levels and register strobes are synchronous to the clock.
- A read strobe and a write strobe never occur in the same cycle.
- Asynchronous general-purpose inputs may change at any time.

The stimulus keeps within these limits. It changes every input a quarter period after the rising edge. It issues each register access as a single-cycle strobe with only one strobe active. It holds general-purpose levels for several cycles, so that every change passes the synchronizer as a clean edge.

// File: rtl/smi_pkg.sv
package smi_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_PERIPH_LVL = 4'd0,
    A_IR_STAT    = 4'd1,
    A_PERIPH_EN  = 4'd2,
    A_ROUTE_EN   = 4'd3,
    A_GPIO_STAT  = 4'd4,
    A_GPIO_EN    = 4'd5,
    A_GPIO_INV   = 4'd6,
    A_GPIO_BOTH  = 4'd7,
    A_PAD_CTL    = 4'd8
  } smi_addr_e;

  localparam int ROUTE_PAD_BIT = 7;
  localparam int ROUTE_SIRQ_BIT = 6;
  localparam int ROUTE_PME_BIT = 5;
  localparam int IR_EN_BIT = 0;
  localparam int PAD_HIGH_BIT = 0;
  localparam int PAD_PP_BIT = 7;
endpackage

// File: rtl/smi_edge_latch.sv
module smi_edge_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] inv_i,
  input  logic [W-1:0] both_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] s1_q, s2_q, s3_q, stat_q;
  logic [W-1:0] rise_w, fall_w, evt_w, stat_d;

  always_comb begin
    rise_w = s2_q & ~s3_q;
    fall_w = ~s2_q & s3_q;
    evt_w  = (both_i & (rise_w | fall_w)) |
             (~both_i & ~inv_i & rise_w) |
             (~both_i & inv_i & fall_w);
    stat_d = (stat_q & ~clr_i) | evt_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      s3_q   <= '0;
      stat_q <= '0;
    end else begin
      s1_q   <= lvl_i;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      stat_q <= stat_d;
    end
  end

  assign stat_o = stat_q;

  p_no_spurious_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q)) & ~$past(s2_q ^ s3_q)) == '0);
  p_w1c_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & $past(clr_i & ~evt_w)) == '0);
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(evt_w) & ~stat_q) == '0);
endmodule

// File: rtl/smi_rdclr_status.sv
module smi_rdclr_status (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic rd_clr_i,
  output logic stat_o
);
  logic stat_q, stat_d;

  always_comb begin
    stat_d = stat_q;
    if (rd_clr_i) stat_d = 1'b0;
    if (evt_i)    stat_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 1'b0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  p_rdclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && !evt_i) |=> !stat_o);
  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> stat_o);
endmodule

// File: rtl/smi_pad_ctrl.sv
module smi_pad_ctrl (
  input  logic assert_i,
  input  logic active_high_i,
  input  logic push_pull_i,
  output logic pad_o,
  output logic oe_o
);
  always_comb begin
    if (push_pull_i) begin
      oe_o  = 1'b1;
      pad_o = assert_i ? active_high_i : ~active_high_i;
    end else begin
      oe_o  = assert_i;
      pad_o = active_high_i;
    end
  end
endmodule

// File: rtl/smi_aggregator.sv
module smi_aggregator
  import smi_pkg::*;
#(
  parameter int NUM_GPIO = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DATA_W-1:0]   periph_evt_i,
  input  logic                ir_evt_i,
  input  logic [NUM_GPIO-1:0] gpio_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic                reg_wr_i,
  input  logic                reg_rd_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic                smi_pad_o,
  output logic                smi_pad_oe_o,
  output logic                serirq_smi_o,
  output logic                pme_smi_o
);
  localparam logic [DATA_W-1:0] ROUTE_MASK =
    DATA_W'((1 << ROUTE_PAD_BIT) | (1 << ROUTE_SIRQ_BIT) | (1 << ROUTE_PME_BIT) | (1 << IR_EN_BIT));
  localparam logic [DATA_W-1:0] PAD_MASK =
    DATA_W'((1 << PAD_HIGH_BIT) | (1 << PAD_PP_BIT));

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [DATA_W-1:0]   en_per_q, en_per_d;
  logic [DATA_W-1:0]   route_q, route_d;
  logic [DATA_W-1:0]   pad_q, pad_d;
  logic [NUM_GPIO-1:0] g_en_q, g_en_d, g_inv_q, g_inv_d, g_both_q, g_both_d;
  logic [NUM_GPIO-1:0] g_clr, g_stat;
  logic                ir_stat, ir_rd;
  logic                wr_hit_route, wr_hit_pad, wr_hit_per;
  logic                group_w, pad_assert;

  always_comb begin
    wr_hit_per   = reg_wr_i && (reg_addr_i == A_PERIPH_EN);
    wr_hit_route = reg_wr_i && (reg_addr_i == A_ROUTE_EN);
    wr_hit_pad   = reg_wr_i && (reg_addr_i == A_PAD_CTL);
    en_per_d = wr_hit_per   ? reg_wdata_i : en_per_q;
    route_d  = wr_hit_route ? (reg_wdata_i & ROUTE_MASK) : route_q;
    pad_d    = wr_hit_pad   ? (reg_wdata_i & PAD_MASK) : pad_q;
    g_en_d   = (reg_wr_i && reg_addr_i == A_GPIO_EN)   ? reg_wdata_i[NUM_GPIO-1:0] : g_en_q;
    g_inv_d  = (reg_wr_i && reg_addr_i == A_GPIO_INV)  ? reg_wdata_i[NUM_GPIO-1:0] : g_inv_q;
    g_both_d = (reg_wr_i && reg_addr_i == A_GPIO_BOTH) ? reg_wdata_i[NUM_GPIO-1:0] : g_both_q;
    g_clr    = (reg_wr_i && reg_addr_i == A_GPIO_STAT) ? reg_wdata_i[NUM_GPIO-1:0] : '0;
    ir_rd    = reg_rd_i && (reg_addr_i == A_IR_STAT);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      en_per_q <= '0;
      route_q  <= '0;
      pad_q    <= '0;
      g_en_q   <= '0;
      g_inv_q  <= '0;
      g_both_q <= '0;
    end else begin
      en_per_q <= en_per_d;
      route_q  <= route_d;
      pad_q    <= pad_d;
      g_en_q   <= g_en_d;
      g_inv_q  <= g_inv_d;
      g_both_q <= g_both_d;
    end
  end

  smi_edge_latch #(.W(NUM_GPIO)) u_gpio (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .lvl_i  (gpio_i),
    .inv_i  (g_inv_q),
    .both_i (g_both_q),
    .clr_i  (g_clr),
    .stat_o (g_stat)
  );

  smi_rdclr_status u_ir (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .evt_i    (ir_evt_i),
    .rd_clr_i (ir_rd),
    .stat_o   (ir_stat)
  );

  assign group_w = (|(periph_evt_i & en_per_q)) |
                   (ir_stat & route_q[IR_EN_BIT]) |
                   (|(g_stat & g_en_q));
  assign pad_assert   = group_w & route_q[ROUTE_PAD_BIT];
  assign serirq_smi_o = group_w & route_q[ROUTE_SIRQ_BIT];
  assign pme_smi_o    = group_w & route_q[ROUTE_PME_BIT];

  smi_pad_ctrl u_pad (
    .assert_i      (pad_assert),
    .active_high_i (pad_q[PAD_HIGH_BIT]),
    .push_pull_i   (pad_q[PAD_PP_BIT]),
    .pad_o         (smi_pad_o),
    .oe_o          (smi_pad_oe_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_PERIPH_LVL: reg_rdata_o = periph_evt_i;
      A_IR_STAT:    reg_rdata_o[0] = ir_stat;
      A_PERIPH_EN:  reg_rdata_o = en_per_q;
      A_ROUTE_EN:   reg_rdata_o = route_q;
      A_GPIO_STAT:  reg_rdata_o[NUM_GPIO-1:0] = g_stat;
      A_GPIO_EN:    reg_rdata_o[NUM_GPIO-1:0] = g_en_q;
      A_GPIO_INV:   reg_rdata_o[NUM_GPIO-1:0] = g_inv_q;
      A_GPIO_BOTH:  reg_rdata_o[NUM_GPIO-1:0] = g_both_q;
      A_PAD_CTL:    reg_rdata_o = pad_q;
      default:      reg_rdata_o = '0;
    endcase
  end

  p_od_level_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!pad_q[PAD_PP_BIT] && smi_pad_oe_o) |-> (smi_pad_o == pad_q[PAD_HIGH_BIT]));
  p_pad_off_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!route_q[ROUTE_PAD_BIT] && !pad_q[PAD_PP_BIT]) |-> !smi_pad_oe_o);
  p_sirq_needs_src_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (serirq_smi_o || pme_smi_o) |-> ((periph_evt_i != '0) || ir_stat || (g_stat != '0)));
  p_per_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$past(wr_hit_per) |-> $stable(en_per_q));
endmodule

// File: tb/smi_aggregator_tb.sv
module smi_aggregator_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] periph = '0;
  logic       ir = 1'b0;
  logic [7:0] gpio = '0;
  logic [3:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       pad, pad_oe, sirq, pme;

  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  smi_aggregator #(.NUM_GPIO(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .periph_evt_i(periph), .ir_evt_i(ir),
    .gpio_i(gpio), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .smi_pad_o(pad),
    .smi_pad_oe_o(pad_oe), .serirq_smi_o(sirq), .pme_smi_o(pme)
  );

  // behavioural reference model
  logic [7:0] m_ena, m_route, m_gen, m_ginv, m_gboth, m_pad, m_gstat;
  logic       m_ir;
  logic [7:0] hist[$];

  task automatic model_reset();
    m_ena = 0; m_route = 0; m_gen = 0; m_ginv = 0; m_gboth = 0;
    m_pad = 0; m_gstat = 0; m_ir = 0;
    hist.delete();
    repeat (3) hist.push_back(8'h00);
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      logic [7:0] nw, od, ev;
      nw = hist[hist.size()-2];
      od = hist[hist.size()-3];
      for (int i = 0; i < 8; i++) begin
        if (m_gboth[i])     ev[i] = nw[i] != od[i];
        else if (m_ginv[i]) ev[i] = !nw[i] && od[i];
        else                ev[i] = nw[i] && !od[i];
      end
      if (wr && addr == 4) m_gstat = m_gstat & ~wdata;
      m_gstat = m_gstat | ev;
      if (rd && addr == 1) m_ir = 0;
      if (ir) m_ir = 1;
      if (wr) case (addr)
        2: m_ena = wdata;
        3: m_route = wdata & 8'hE1;
        5: m_gen = wdata;
        6: m_ginv = wdata;
        7: m_gboth = wdata;
        8: m_pad = wdata & 8'h81;
        default: ;
      endcase
      hist.push_back(gpio);
      if (hist.size() > 4) void'(hist.pop_front());
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    logic grp, asrt, act;
    logic [7:0] er;
    grp  = |(periph & m_ena) | (m_ir & m_route[0]) | |(m_gstat & m_gen);
    asrt = grp & m_route[7];
    act  = m_pad[0];
    case (addr)
      0: er = periph;  1: er = {7'b0, m_ir}; 2: er = m_ena; 3: er = m_route;
      4: er = m_gstat; 5: er = m_gen; 6: er = m_ginv; 7: er = m_gboth;
      8: er = m_pad;   default: er = 8'h00;
    endcase
    chk("R10 rdata", rdata, er);
    chk("R8 serirq", {7'b0, sirq}, {7'b0, grp & m_route[6]});
    chk("R8 pme", {7'b0, pme}, {7'b0, grp & m_route[5]});
    if (m_pad[7]) begin
      chk("R9 oe", {7'b0, pad_oe}, 8'h01);
      chk("R9 pad", {7'b0, pad}, {7'b0, asrt ? act : ~act});
    end else begin
      chk("R9 oe", {7'b0, pad_oe}, {7'b0, asrt});
      chk("R9 pad", {7'b0, pad}, {7'b0, act});
    end
  end

  task automatic step(); @(posedge clk); #5; endtask
  task automatic wreg(logic [3:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1; step(); wr = 0;
  endtask
  task automatic rreg(logic [3:0] a, output logic [7:0] d);
    addr = a; rd = 1; #4 d = rdata; step(); rd = 0;
  endtask
  task automatic peek(logic [3:0] a, output logic [7:0] d);
    addr = a; #4 d = rdata;
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    #35 rst_n = 1;
    repeat (4) step();
    // R10 reset state
    for (int a = 0; a < 16; a++) begin peek(a[3:0], d); chk("R10 reset read", d, 8'h00); end
    chk("R10 pad released", {7'b0, pad_oe}, 8'h00);
    chk("R9 reset active-low", {7'b0, pad}, 8'h00);
    // R2 live peripheral levels, write ignored
    wreg(0, 8'hFF); peek(0, d); chk("R2 write ignored", d, 8'h00);
    periph = 8'h24; step(); peek(0, d); chk("R2 live level", d, 8'h24);
    chk("R1 disabled no request", {7'b0, sirq}, 8'h00);
    wreg(3, 8'hFF); peek(3, d); chk("R8 route readback", d, 8'hE1);
    wreg(2, 8'h04); peek(0, d);
    chk("R1 enabled source", {7'b0, sirq}, 8'h01);
    periph = 8'h20; step(); chk("R1 disabled source only", {7'b0, sirq}, 8'h00);
    periph = 8'h00; wreg(2, 8'h00);
    // R3 infrared read clear
    ir = 1; step(); ir = 0; step(); step();
    rreg(1, d); chk("R3 read returns set", d, 8'h01);
    peek(1, d); chk("R3 cleared after read", d, 8'h00);
    ir = 1; step(); rreg(1, d); chk("R3 read while high", d, 8'h01);
    peek(1, d); chk("R3 level keeps set", d, 8'h01);
    ir = 0; rreg(1, d); peek(1, d); chk("R3 cleared", d, 8'h00);
    // R4 rising edge latency
    wreg(5, 8'hFF);
    gpio = 8'h01; step(); step(); peek(4, d); chk("R4 not before third edge", d, 8'h00);
    step(); peek(4, d); chk("R4 set on third edge", d, 8'h01);
    chk("R1 gpio source", {7'b0, sirq}, 8'h01);
    gpio = 8'h00; repeat (4) step(); peek(4, d); chk("R4 fall ignored", d, 8'h01);
    // R7 w1c
    wreg(4, 8'h00); peek(4, d); chk("R7 write 0 keeps", d, 8'h01);
    wreg(4, 8'h01); peek(4, d); chk("R7 write 1 clears", d, 8'h00);
    // R5 inverted polarity
    wreg(6, 8'h02); gpio = 8'h02; repeat (4) step(); peek(4, d); chk("R5 rise ignored", d, 8'h00);
    gpio = 8'h00; repeat (4) step(); peek(4, d); chk("R5 fall sets", d, 8'h02);
    wreg(4, 8'hFF);
    // R6 both edges
    wreg(7, 8'h04); gpio = 8'h04; repeat (4) step(); peek(4, d); chk("R6 rise sets", d, 8'h04);
    wreg(4, 8'h04); gpio = 8'h00; repeat (4) step(); peek(4, d); chk("R6 fall sets", d, 8'h04);
    wreg(4, 8'h04);
    // R7 set wins over clear in same cycle
    gpio = 8'h08; step(); step();
    wreg(4, 8'h08); peek(4, d); chk("R7 set wins", d, 8'h08);
    gpio = 8'h00; wreg(4, 8'hFF); repeat (4) step();
    // R9 pad modes
    wreg(5, 8'h00); wreg(2, 8'h01); periph = 8'h01; step();
    chk("R9 od active-low oe", {7'b0, pad_oe}, 8'h01);
    chk("R9 od active-low data", {7'b0, pad}, 8'h00);
    wreg(8, 8'h81); chk("R9 pp active-high", {7'b0, pad}, 8'h01);
    periph = 8'h00; step(); chk("R9 pp idle low", {7'b0, pad}, 8'h00);
    chk("R9 pp oe on", {7'b0, pad_oe}, 8'h01);
    wreg(3, 8'h00); periph = 8'h01; step(); chk("R8 pad route off", {7'b0, pad}, 8'h00);
    chk("R8 pme off", {7'b0, pme}, 8'h00);
    wreg(3, 8'h20); chk("R8 pme on", {7'b0, pme}, 8'h01);
    periph = 8'h00; repeat (3) step();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule